// File: doc/BRIEF.md
# Readout Timeslot Character Sequencer

This block follows the repeating train of ten timeslot strobes that a display readout system issues. For every accepted slot it presents a character as two 4-bit weighted codes (row and column) on each of two display channels. Downstream current sinks turn these codes into analog row and column currents. The block does not take its characters from a host. A built-in exercise pattern supplies them: a slow page timer walks through five pages, and each page holds ten characters, one for each slot. Over a full sweep this gives fifty characters on each channel.

Strobes reach the block in one of two arrangements. In the merged arrangement, one line carries slot 1 and a second shared line carries slots 2 to 10. Each pulse on the shared line moves the slot index on by one. In the per-slot arrangement, every slot has its own line, and the block checks that each slot arrives in its expected position. A slot-1 strobe always restarts the cycle. When it cuts a cycle short, the block reports this with a pulse.

Top module: `rdo_slot_seq`

## Requirements
- R1: After reset, all four code outputs, `slot_num`, `page_num`, `order_err` and `short_err` are zero. The codes stay zero until the first slot-1 strobe has been accepted.
- R2: Each strobe line passes through a two-flop synchronizer and is acted on only at its rising edge. A line that is first sampled high at clock edge N takes effect at edge N+2. A line held high acts once.
- R3: A rising edge on line 0 (`strobe_in[0]`) sets `slot_num` to 1 in both arrangements. If a rising edge on another line arrives in the same cycle, it is ignored.
- R4: In the merged arrangement (`per_slot_mode`=0), a rising edge on `strobe_in[1]` moves `slot_num` from k to k+1 for k in 1..9. When `slot_num` is 0 or 10, that edge instead pulses `order_err` for one cycle and changes no other output. Lines 2 to 9 have no effect.
- R5: In the per-slot arrangement (`per_slot_mode`=1), a rising edge on line k (`strobe_in[k]`, which belongs to slot k+1) is accepted only when `slot_num` equals k and no other line rises. Any other rising edge on lines 1 to 9 pulses `order_err` and leaves all other outputs unchanged.
- R6: `short_err` pulses for one cycle when a slot-1 strobe is accepted while `slot_num` is in 1..9. It stays low when `slot_num` is 0 or 10.
- R7: On each accepted slot s, with page p, the outputs become: `ch_a_row`=s, `ch_a_col`=p+1, `ch_b_row`=11-s and `ch_b_col`=5-p. These are plain binary codes with bit weights 8, 4, 2 and 1.
- R8: Between accepted slots, all code outputs hold their last value, even while the page changes.
- R9: `page_num` advances by one every PAGE_CYCLES clocks and returns to 0 after 4. PAGE_CYCLES equals CLK_HZ (one second), unless the override parameter is non-zero.
- R10: If a slot is accepted on the same edge as a page advance, its column codes use the page from before the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_slot_mode | input | 1 | 0: merged arrangement, 1: one line per slot |
| strobe_in | input | 10 | Logic-level timeslot strobes; bit 0 is slot 1 |
| slot_num | output | 4 | Current slot index, 0 before the first slot 1 |
| page_num | output | 3 | Exercise page, 0 to 4 |
| ch_a_row | output | 4 | Channel A row code |
| ch_a_col | output | 4 | Channel A column code |
| ch_b_row | output | 4 | Channel B row code |
| ch_b_col | output | 4 | Channel B column code |
| order_err | output | 1 | One-cycle pulse: a slot was missing, out of order or extra |
| short_err | output | 1 | One-cycle pulse: slot 1 arrived before slot 10 |

## Verification
The page timer and the slot tracker share the column codes, and the two can act on the same clock edge. The bench provokes this deliberately. It watches its own model of the page count and raises a shared-line strobe exactly two edges before the count wraps. It then expects the column code to show the old page while `page_num` already shows the new one. The page period is made odd and shorter than a strobe cycle, so many further collisions occur unprompted. The per-clock reference model judges every one of them.

// File: rtl/rdo_slot_seq.sv
module rdo_slot_seq #(
  parameter int CLK_HZ          = 200_000_000,
  parameter int PAGE_CYCLES_OVR = 0,
  parameter int SLOTS           = 10,
  parameter int PAGES           = 5,
  parameter int CW              = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_slot_mode,
  input  logic [SLOTS-1:0] strobe_in,
  output logic [3:0]       slot_num,
  output logic [2:0]       page_num,
  output logic [CW-1:0]    ch_a_row,
  output logic [CW-1:0]    ch_a_col,
  output logic [CW-1:0]    ch_b_row,
  output logic [CW-1:0]    ch_b_col,
  output logic             order_err,
  output logic             short_err
);
  localparam int PAGE_CYCLES = (PAGE_CYCLES_OVR != 0) ? PAGE_CYCLES_OVR : CLK_HZ;
  localparam int TW          = $clog2(PAGE_CYCLES + 1);

  logic [SLOTS-1:0] s1, s2, s3;
  logic [TW-1:0]    tick;
  logic [3:0]       nxt;
  logic             take, err, shrt;

  wire [SLOTS-1:0] rise      = s2 & ~s3;
  wire             mid_cycle = (slot_num != 4'd0) && (slot_num != 4'(SLOTS));
  wire             last_tick = (tick == TW'(PAGE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {strobe_in, s1, s2};

  always_comb begin
    take = 1'b0;
    err  = 1'b0;
    shrt = 1'b0;
    nxt  = slot_num;
    if (rise[0]) begin
      take = 1'b1;
      nxt  = 4'd1;
      shrt = mid_cycle;
    end else if (!per_slot_mode) begin
      if (rise[1]) begin
        if (mid_cycle) begin
          take = 1'b1;
          nxt  = slot_num + 4'd1;
        end else err = 1'b1;
      end
    end else if (|rise) begin
      if (mid_cycle && rise == (SLOTS'(1) << slot_num)) begin
        take = 1'b1;
        nxt  = slot_num + 4'd1;
      end else err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slot_num  <= '0;
      ch_a_row  <= '0;
      ch_a_col  <= '0;
      ch_b_row  <= '0;
      ch_b_col  <= '0;
      order_err <= 1'b0;
      short_err <= 1'b0;
    end else begin
      order_err <= err;
      short_err <= shrt;
      if (take) begin
        slot_num <= nxt;
        ch_a_row <= CW'(nxt);
        ch_a_col <= CW'(page_num) + CW'(1);
        ch_b_row <= CW'(SLOTS + 1) - CW'(nxt);
        ch_b_col <= CW'(PAGES) - CW'(page_num);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tick     <= '0;
      page_num <= '0;
    end else if (last_tick) begin
      tick     <= '0;
      page_num <= (page_num == 3'(PAGES - 1)) ? 3'd0 : page_num + 3'd1;
    end else tick <= tick + TW'(1);
endmodule

// File: rtl/rdo_slot_seq_chk.sv
module rdo_slot_seq_chk #(
  parameter int SLOTS = 10,
  parameter int PAGES = 5,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    slot_num,
  input logic [2:0]    page_num,
  input logic [CW-1:0] ch_a_row,
  input logic [CW-1:0] ch_a_col,
  input logic [CW-1:0] ch_b_row,
  input logic [CW-1:0] ch_b_col,
  input logic          order_err,
  input logic          short_err
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    slot_num == 4'd0 |-> (ch_a_row == '0 && ch_a_col == '0 && ch_b_row == '0 && ch_b_col == '0)); // R1
  AST_ROW_A: assert property (@(posedge clk) disable iff (!rst_n)
    slot_num != 4'd0 |-> ch_a_row == CW'(slot_num)); // R7
  AST_ROW_B: assert property (@(posedge clk) disable iff (!rst_n)
    slot_num != 4'd0 |-> ch_b_row == CW'(SLOTS + 1) - CW'(slot_num)); // R7
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    slot_num != $past(slot_num) |-> (slot_num == 4'd1 || slot_num == $past(slot_num) + 4'd1)); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |-> $stable(slot_num)); // R5
  AST_SHORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> (slot_num == 4'd1 && !order_err)); // R6
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    page_num != $past(page_num) |->
      page_num == (($past(page_num) == 3'(PAGES - 1)) ? 3'd0 : $past(page_num) + 3'd1)); // R9
  AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    page_num < 3'(PAGES)); // R9
endmodule

bind rdo_slot_seq rdo_slot_seq_chk #(.SLOTS(SLOTS), .PAGES(PAGES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_num(slot_num), .page_num(page_num),
  .ch_a_row(ch_a_row), .ch_a_col(ch_a_col), .ch_b_row(ch_b_row), .ch_b_col(ch_b_col),
  .order_err(order_err), .short_err(short_err));

// File: tb/sim_rdo_slot_seq.sv
`timescale 1ns/1ps
module sim_rdo_slot_seq;
  localparam int P = 61;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       per_slot_mode = 1'b0;
  logic [9:0] strobe_in = '0;
  logic [3:0] slot_num;
  logic [2:0] page_num;
  logic [3:0] ch_a_row, ch_a_col, ch_b_row, ch_b_col;
  logic       order_err, short_err;

  int checks = 0, errors = 0;
  int m_slot = 0, m_page = 0, m_cnt = 0, m_oerr = 0, m_serr = 0;
  int m_ar = 0, m_ac = 0, m_br = 0, m_bc = 0;
  logic [9:0] hist[$] = '{10'd0, 10'd0, 10'd0, 10'd0};
  bit seen_wrap = 0;

  always #2.5 clk = ~clk;

  rdo_slot_seq #(.PAGE_CYCLES_OVR(P)) u0 (
    .clk(clk), .rst_n(rst_n), .per_slot_mode(per_slot_mode), .strobe_in(strobe_in),
    .slot_num(slot_num), .page_num(page_num), .ch_a_row(ch_a_row), .ch_a_col(ch_a_col),
    .ch_b_row(ch_b_row), .ch_b_col(ch_b_col), .order_err(order_err), .short_err(short_err));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_page = 0; m_cnt = 0; m_oerr = 0; m_serr = 0;
      m_ar = 0; m_ac = 0; m_br = 0; m_bc = 0;
      hist = '{10'd0, 10'd0, 10'd0, 10'd0};
    end else begin
      logic [9:0] r;
      int nx;
      bit acc, mid;
      hist.push_front(strobe_in);
      void'(hist.pop_back());
      r = hist[2] & ~hist[3];
      mid = (m_slot >= 1 && m_slot <= 9);
      acc = 0; nx = m_slot; m_oerr = 0; m_serr = 0;
      if (r[0]) begin acc = 1; nx = 1; m_serr = mid; end
      else if (!per_slot_mode) begin
        if (r[1]) begin if (mid) begin acc = 1; nx = m_slot + 1; end else m_oerr = 1; end
      end else if (r != 0) begin
        if (mid && r == (10'd1 << m_slot)) begin acc = 1; nx = m_slot + 1; end else m_oerr = 1;
      end
      if (acc) begin
        m_slot = nx; m_ar = nx; m_ac = m_page + 1; m_br = 11 - nx; m_bc = 5 - m_page;
      end
      if (m_cnt == P - 1) begin
        m_cnt = 0;
        if (m_page == 4) seen_wrap = 1;
        m_page = (m_page + 1) % 5;
      end else m_cnt++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(slot_num, m_slot, "R3 R4 R5 slot");
    chk(page_num, m_page, "R9 page");
    chk({ch_a_row, ch_a_col, ch_b_row, ch_b_col}, {m_ar[3:0], m_ac[3:0], m_br[3:0], m_bc[3:0]}, "R7 codes");
    chk(order_err, m_oerr, "R4 R5 order_err");
    chk(short_err, m_serr, "R6 short_err");
  end

  task automatic strobe(input int line, input int hi = 20, input int lo = 12);
    @(negedge clk) strobe_in[line] = 1'b1;
    repeat (hi) @(negedge clk);
    strobe_in[line] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({slot_num, page_num, ch_a_row, ch_a_col, ch_b_row, ch_b_col, order_err, short_err}, 0, "R1 reset state");

    strobe(1);
    chk(slot_num, 0, "R4 shared strobe before slot 1");

    // R2: latency and single action while held high
    @(negedge clk) strobe_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(slot_num, 0, "R2 not yet registered");
    @(negedge clk);
    chk(slot_num, 1, "R2 taken after two-flop sync");
    repeat (30) @(negedge clk);
    chk(slot_num, 1, "R2 held level acts once");
    strobe_in[0] = 1'b0;
    repeat (8) @(negedge clk);

    for (int k = 2; k <= 10; k++) strobe(1);
    chk(slot_num, 10, "R4 full merged cycle");
    chk(ch_b_row, 1, "R7 channel B row at slot 10");
    strobe(5);
    chk(slot_num, 10, "R4 unused line ignored");
    strobe(1);
    chk(slot_num, 10, "R4 extra shared strobe held");

    strobe(0);
    chk(slot_num, 1, "R6 restart after full cycle");
    for (int k = 2; k <= 4; k++) strobe(1);
    begin
      logic [15:0] held;
      held = {ch_a_row, ch_a_col, ch_b_row, ch_b_col};
      repeat (2 * P) @(negedge clk);
      chk({ch_a_row, ch_a_col, ch_b_row, ch_b_col}, held, "R8 codes held across page changes");
    end
    strobe(0);
    chk(slot_num, 1, "R6 short cycle restart");

    // R10: slot accepted on the page-advance edge
    begin
      int oldp;
      while (m_cnt != P - 3) @(negedge clk);
      oldp = m_page;
      strobe_in[1] = 1'b1;
      repeat (3) @(negedge clk);
      chk(ch_a_col, oldp + 1, "R10 column from old page");
      chk(page_num, (oldp + 1) % 5, "R10 page already advanced");
      strobe_in[1] = 1'b0;
      repeat (8) @(negedge clk);
    end

    per_slot_mode = 1'b1;
    strobe(0);
    for (int k = 1; k <= 9; k++) strobe(k);
    chk(slot_num, 10, "R5 per-slot full cycle");
    strobe(0);
    chk(slot_num, 1, "R6 no short after slot 10");
    strobe(1); strobe(2);
    strobe(4);
    chk(slot_num, 3, "R5 missing slot rejected");
    strobe(2);
    chk(slot_num, 3, "R5 repeated slot rejected");
    fork strobe(3); strobe(5); join
    chk(slot_num, 3, "R5 two lines at once rejected");
    fork strobe(0); strobe(7); join
    chk(slot_num, 1, "R3 slot 1 wins over other line");

    for (int c = 0; c < 4; c++) begin
      for (int k = 1; k <= 9; k++) strobe(k, 15, 9);
      strobe(0, 15, 9);
    end
    per_slot_mode = 1'b0;
    for (int c = 0; c < 3; c++) begin
      for (int k = 1; k <= 9; k++) strobe(1, 11, 7);
      strobe(0, 11, 7);
    end
    chk(seen_wrap, 1, "R9 page wrapped 4 to 0");
    finish_run();
  end
endmodule